// File: doc/BRIEF.md
# Tiny 8-bit Multi-Cycle Processor Core

This block is a compact processor core. Each instruction is one byte, and the data path is eight bits wide. The core holds four general registers, a program counter and three separate sign flags (negative, zero, positive). It runs every instruction through a fixed sequence of phases over a single synchronous memory port. A read returns its data in the cycle after the address is presented. A write happens in the cycle where the write enable is high.

The instruction set covers eight operations:

- two-operand add and bitwise AND, with a register or a tiny immediate as second source;
- bitwise complement;
- load of a signed constant into register 0;
- load of a PC-relative address into register 0;
- memory load and store through a register pointer;
- a conditional jump to an address held in a register.

The reset input is asynchronous and active-low. Inside the block it is released on a clock edge through a two-stage synchronizer.

Top module: `tiny8_core`

## Requirements
- R1: While reset is held and after its release, the core clears PC, all four registers and the N and P flags, sets Z to 1, keeps mem_we low and presents address 0 for the first fetch.
- R2: Every instruction takes four cycles (fetch, decode, execute, writeback). Loads and stores add one memory cycle between execute and writeback. PC advances by one during decode. Two clock edges after reset is released, the core begins its first fetch.
- R3: Opcode bits [7:5]=000 is ADD. It writes reg[ir[4:3]] + src back to reg[ir[4:3]]. When ir[2]=0, src is reg[ir[1:0]]. When ir[2]=1, src is ir[1:0] sign-extended to 8 bits.
- R4: Opcode 001 is AND. It uses the same fields and source steering as ADD, and writes the bitwise AND.
- R5: Opcode 111 replaces reg[ir[4:3]] with its bitwise complement.
- R6: Opcode 011 writes ir[4:0] sign-extended into register 0.
- R7: Opcode 100 writes into register 0 the sum of the instruction's own address plus one and ir[4:0] sign-extended.
- R8: Opcode 101 loads mem[reg[ir[1:0]]] into reg[ir[4:3]].
- R9: Opcode 110 writes reg[ir[4:3]] to mem[reg[ir[1:0]]]. mem_we is high for exactly one cycle, and the address during that cycle is the pointer register.
- R10: Opcode 010 selects flags with ir[4] (N), ir[3] (Z) and ir[2] (P). If any selected flag is set, PC becomes reg[ir[1:0]]. Otherwise execution continues with the next byte.
- R11: Every register-writing instruction sets exactly one flag from the written value: N if bit 7 is set, Z if the value is zero, P otherwise. Store and jump leave the flags unchanged.
- R12: A set bit in a must-be-zero position has no effect. This covers ir[2:0] of complement and ir[2] of load and store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address (PC, or the pointer register during the memory phase) |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |

## Verification
Arithmetic and logic are swept over every 5-bit constant loaded into register 0. Each constant is combined with each of the four immediates and with a register operand. This separates sign-extension, carry and masking faults. Each result is stored to memory and then followed by a conditional jump. The jump runs once with the expected flag as its mask and once with the other two flags, so a wrong flag, a missing flag or an extra flag each shows up as a wrong taken/not-taken outcome. A second program covers pointer load and store, PC-relative address formation with positive and negative offsets, must-be-zero bits and register reset values. A timing run pins down the cycle of the first store.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_AND = 3'd1, OP_BR  = 3'd2, OP_LDI = 3'd3,
    OP_LEA = 3'd4, OP_LD  = 3'd5, OP_ST  = 3'd6, OP_NOT = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB
  } phase_e;

  localparam int IW = 8;
endpackage

// File: rtl/tiny8_rst_sync.sv
module tiny8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/tiny8_ctrl.sv
module tiny8_ctrl
  import tiny8_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e op,
  output phase_e  phase
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_FETCH:  ph_d = PH_DECODE;
      PH_DECODE: ph_d = PH_EXEC;
      PH_EXEC:   ph_d = (op == OP_LD || op == OP_ST) ? PH_MEM : PH_WB;
      PH_MEM:    ph_d = PH_WB;
      default:   ph_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_FETCH;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

  AST_MEM_LDST: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_MEM) |-> (op == OP_LD || op == OP_ST)); // R8
  AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WB) |=> (ph_q == PH_FETCH)); // R2
endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [DW-1:0]           rdata_a,
  output logic [DW-1:0]           rdata_b
);
  localparam int RW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == RW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu
  import tiny8_pkg::*;
#(
  parameter int DW = 8
) (
  input  opcode_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] pc,
  input  logic [4:0]    imm5,
  output logic [DW-1:0] y
);
  logic [DW-1:0] imm_ext;
  assign imm_ext = {{(DW-5){imm5[4]}}, imm5};

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_AND:  y = a & b;
      OP_NOT:  y = ~a;
      OP_LDI:  y = imm_ext;
      OP_LEA:  y = pc + imm_ext;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import tiny8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  localparam int RW = $clog2(NREG);

  logic          rst_i_n;
  phase_e        phase;
  opcode_e       op;
  logic [IW-1:0] ir_q, ir_d;
  logic [DW-1:0] pc_q, pc_d, res_q, res_d;
  logic          n_q, z_q, p_q, n_d, z_d, p_d;
  logic [DW-1:0] ra_val, rb_val, src_b, alu_y, wval;
  logic [RW-1:0] waddr;
  logic          rf_we, br_hit;
  logic          ir_en, pc_en, res_en, cc_en;

  tiny8_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign op = opcode_e'(ir_q[7:5]);

  tiny8_ctrl u_ctrl (.clk(clk), .rst_n(rst_i_n), .op(op), .phase(phase));

  tiny8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_i_n), .we(rf_we), .waddr(waddr), .wdata(wval),
    .raddr_a(RW'(ir_q[4:3])), .raddr_b(RW'(ir_q[1:0])),
    .rdata_a(ra_val), .rdata_b(rb_val));

  assign src_b = ir_q[2] ? {{(DW-2){ir_q[1]}}, ir_q[1:0]} : rb_val;

  tiny8_alu #(.DW(DW)) u_alu (
    .op(op), .a(ra_val), .b(src_b), .pc(pc_q), .imm5(ir_q[4:0]), .y(alu_y));

  // Writeback selection
  assign wval   = (op == OP_LD) ? mem_rdata : res_q;
  assign waddr  = (op == OP_LDI || op == OP_LEA) ? '0 : RW'(ir_q[4:3]);
  assign rf_we  = (phase == PH_WB) && (op != OP_ST) && (op != OP_BR);
  assign br_hit = |(ir_q[4:2] & {n_q, z_q, p_q});

  // Clock enables
  assign ir_en  = (phase == PH_DECODE);
  assign res_en = (phase == PH_EXEC);
  assign cc_en  = rf_we;
  assign pc_en  = (phase == PH_DECODE) ||
                  ((phase == PH_WB) && (op == OP_BR) && br_hit);

  // Next-state values
  always_comb begin
    ir_d  = mem_rdata[IW-1:0];
    res_d = alu_y;
    pc_d  = (phase == PH_DECODE) ? pc_q + 1'b1 : rb_val;
    n_d   = wval[DW-1];
    z_d   = (wval == '0);
    p_d   = !wval[DW-1] && (wval != '0);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ir_q  <= '0;
      pc_q  <= '0;
      res_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b1;
      p_q   <= 1'b0;
    end else begin
      if (ir_en)  ir_q  <= ir_d;
      if (pc_en)  pc_q  <= pc_d;
      if (res_en) res_q <= res_d;
      if (cc_en) begin
        n_q <= n_d;
        z_q <= z_d;
        p_q <= p_d;
      end
    end
  end

  // Memory port
  assign mem_addr  = (phase == PH_MEM) ? rb_val : pc_q;
  assign mem_wdata = ra_val;
  assign mem_we    = (phase == PH_MEM) && (op == OP_ST);

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones({n_q, z_q, p_q}) == 1); // R11
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((phase == PH_WB) && (op == OP_ST || op == OP_BR)) |=> $stable({n_q, z_q, p_q})); // R11
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase == PH_DECODE) |=> (pc_q == $past(pc_q) + 1'b1)); // R2
  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((phase == PH_WB) && (op == OP_BR) && !br_hit) |=> $stable(pc_q)); // R10
  AST_WE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |-> (phase == PH_MEM && op == OP_ST)); // R9
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |=> !mem_we); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> (!mem_we && mem_addr == '0)); // R1
endmodule

// File: tb/sim_tiny8_core.sv
`timescale 1ns/1ps
module sim_tiny8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] mem [256];
  int         nchecks = 0;
  int         nerrors = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  tiny8_core u0 (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
                 .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      nerrors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] cc_mask(input logic [7:0] v);
    if (v[7])          return 8'h10;
    else if (v == 8'h0) return 8'h08;
    else               return 8'h04;
  endfunction

  // Template: R1=F0 pointer, R2=12 target; op applied to R0=x; store; branch.
  task automatic alu_case(input string req, input logic [7:0] opw,
                          input logic [7:0] x, input logic [7:0] expv);
    for (int pass = 0; pass < 2; pass++) begin
      logic [7:0] m;
      m = (pass == 0) ? cc_mask(expv) : (8'h1C ^ cc_mask(expv));
      hold_reset();
      clear_mem();
      mem[0] = 8'h70; mem[1] = 8'h08; mem[2] = 8'h6C; mem[3] = 8'h10;
      mem[4] = 8'h60 | (x & 8'h1F); mem[5] = opw; mem[6] = 8'hC1;
      mem[7] = 8'h42 | m; mem[8] = 8'h0D; mem[9] = 8'hD1;
      mem[10] = 8'h40; mem[11] = 8'h40; mem[12] = 8'h80; mem[13] = 8'h5C;
      mem[8'hF1] = 8'hAA;
      run(100);
      if (pass == 0) check(req, mem[8'hF0], expv);
      if (pass == 0) check("R11 R10 flag taken", mem[8'hF1], 8'hAA);
      else           check("R11 R10 flag not taken", mem[8'hF1], 8'h0C);
    end
  endtask

  initial begin
    int first_we;
    logic [7:0] x, k2;
    // R1 and R2: reset state and cycle of first store
    hold_reset();
    clear_mem();
    mem[0] = 8'h70; mem[1] = 8'h08; mem[2] = 8'h6C; mem[3] = 8'h10;
    mem[4] = 8'h63; mem[5] = 8'h40; mem[6] = 8'hC1; mem[7] = 8'h40;
    check("R1 reset addr", mem_addr, 8'h00);
    check("R1 reset we", {7'b0, mem_we}, 8'h00);
    rst_n = 1'b1;
    check("R1 first fetch addr", mem_addr, 8'h00);
    first_we = -1;
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk); @(negedge clk);
      if (mem_we && first_we < 0) begin
        first_we = k;
        check("R9 store addr", mem_addr, 8'hF0);
        check("R9 store data", mem_wdata, 8'h03);
      end
    end
    // 2 sync edges + 6 four-cycle instructions + fetch/decode/exec of the store
    check("R2 first store cycle", 8'(first_we), 8'd29);

    // Sweeps over every 5-bit constant
    for (int xi = 0; xi < 32; xi++) begin
      x = {{3{xi[4]}}, xi[4:0]};
      alu_case("R6 load constant", 8'h40, x, x);
      alu_case("R5 complement", 8'hE0, x, ~x);
      alu_case("R3 add register", 8'h02, x, x + 8'd12);
      alu_case("R4 and register", 8'h22, x, x & 8'd12);
      for (int k = 0; k < 4; k++) begin
        k2 = {{6{k[1]}}, k[1:0]};
        alu_case("R3 add immediate", 8'h04 | 8'(k), x, x + k2);
        alu_case("R4 and immediate", 8'h24 | 8'(k), x, x & k2);
      end
    end

    // R7 R8 R12 program
    hold_reset();
    clear_mem();
    mem[0] = 8'h70; mem[1] = 8'h08; mem[2] = 8'hB9; mem[3] = 8'hFD;
    mem[4] = 8'h0D; mem[5] = 8'hDD; mem[6] = 8'h85; mem[7] = 8'h0D;
    mem[8] = 8'hC1; mem[9] = 8'h9D; mem[10] = 8'h0D; mem[11] = 8'hC1;
    mem[12] = 8'h0D; mem[13] = 8'hD1; mem[14] = 8'h80; mem[15] = 8'h5C;
    mem[8'hF0] = 8'h5A; mem[8'hF4] = 8'hEE;
    run(120);
    check("R8 load source untouched", mem[8'hF0], 8'h5A);
    check("R8 R12 load then complement", mem[8'hF1], 8'hA5);
    check("R7 positive offset", mem[8'hF2], 8'h0C);
    check("R7 negative offset", mem[8'hF3], 8'h07);
    check("R1 register reset value", mem[8'hF4], 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule